// File: doc/BRIEF.md
# Gate-Drive Fault Shutdown Filter

This block sits between the PWM generators and the gate-drive output pins of a motor inverter with a power-factor stage. It passes six inverter gate commands and one PFC gate command through to the pins. It watches two fault pins. The main fault pin shuts down all six inverter gates. The PFC fault pin shuts down only the PFC gate.

Each fault pin is first synchronised. It is then compared against a programmable active level. Finally it is qualified by a counter that must see the active level on consecutive cycles for a programmable count (`filt_len`). Short glitches are therefore rejected. Once a fault is qualified, a latch is set. The latch holds the affected gates at their inactive level until software pulses a clear strobe, and that strobe is ignored while the qualified fault is still present.

Each gate output has its own programmable polarity. When the PFC fault pin is given over to general-purpose use, its input is ignored and the main fault latch also shuts down the PFC gate.

Top module: `gate_kill_guard`

## Requirements
- R1: A latched main fault drives all six inverter gate pins to their inactive level. While the PFC pin is not in general-purpose mode, a latched main fault leaves the PFC gate pin unaffected.
- R2: A latched PFC fault drives only the PFC gate pin to its inactive level. The six inverter pins keep following their commands.
- R3: Each fault pin has its own active-level select: `1` means a high pin is a fault, `0` means a low pin is a fault.
- R4: A fault is recognised only after the synchronised pin has been at its active level for `filt_len` consecutive cycles. A shorter pulse has no effect. A `filt_len` of 0 behaves as 1.
- R5: With a fault pin changed just before clock edge 1, the forced level first appears on the gate pins after edge `filt_len`+3, and the pins still follow their commands after edge `filt_len`+2.
- R6: A latched fault keeps the gates forced after the fault pin returns inactive, until a clear strobe is seen on a cycle with no qualified fault.
- R7: A clear strobe on a cycle in which the fault is still qualified has no effect. The gates stay forced.
- R8: Each gate pin has a polarity bit. With the bit at `1`, a command of 1 drives the pin high. With the bit at `0`, a command of 1 drives the pin low. The inactive pin level is the inverse of the polarity bit.
- R9: With `pfc_pin_is_gpio` at 1, the PFC fault pin is ignored and a latched main fault also drives the PFC gate pin inactive.
- R10: During and just after reset, every gate pin sits at its inactive level and no fault is latched.
- R11: With no latched fault, each gate pin follows its command one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_cmd | input | N_INV | Inverter gate commands, 1 = switch on |
| pfc_cmd | input | 1 | PFC gate command, 1 = switch on |
| main_fault_pin | input | 1 | Main fault pin (asynchronous) |
| pfc_fault_pin | input | 1 | PFC fault pin (asynchronous) |
| main_fault_hi | input | 1 | Main fault active level, 1 = high |
| pfc_fault_hi | input | 1 | PFC fault active level, 1 = high |
| pfc_pin_is_gpio | input | 1 | PFC fault pin reassigned; use main fault for PFC |
| filt_len | input | CNT_W | Qualification length in cycles (0 acts as 1) |
| fault_clear | input | 1 | Clear strobe for latched faults |
| inv_act_hi | input | N_INV | Per-inverter-gate polarity, 1 = active high |
| pfc_act_hi | input | 1 | PFC gate polarity, 1 = active high |
| inv_gate | output | N_INV | Inverter gate pins |
| pfc_gate | output | 1 | PFC gate pin |

## Verification
The assertions check on every cycle that a qualified fault is latched on the next edge. They also check that the latch neither rises without qualification nor falls without a usable clear, and that a clear during qualification is ignored. Two more properties hold on each gate pin: a kill forces the inactive level one cycle later, and otherwise the pin tracks the command under its polarity. A further property holds for the PFC pin in general-purpose mode.

Several behaviours can only be shown by the bench's scenarios, which a behavioural cycle model compares on each clock:
- the exact end-to-end latency through the synchroniser and the counter;
- rejection of a pulse one cycle shorter than `filt_len`;
- active-low fault pins;
- the zero-length setting.

// File: rtl/gk_pkg.sv
package gk_pkg;
   // Map a logical gate state (1 = switch on) to the pin level for a polarity.
   function automatic logic to_pin(input logic on_state, input logic act_hi);
      return ~(on_state ^ act_hi);
   endfunction
endpackage

// File: rtl/gk_sync.sv
module gk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic q_vld
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gk_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shreg;
   logic [STAGES-1:0] vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         vld   <= '0;
      end else begin
         shreg <= {shreg[STAGES-2:0], d};
         vld   <= {vld[STAGES-2:0], 1'b1};
      end
   end

   assign q     = shreg[STAGES-1];
   assign q_vld = vld[STAGES-1];
endmodule

// File: rtl/gk_qualifier.sv
module gk_qualifier #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_vld,
   input  logic             lvl,
   input  logic             act_hi,
   input  logic             enable,
   input  logic [CNT_W-1:0] filt_len,
   input  logic             clr,
   output logic             latched
);
   if (CNT_W < 2) begin : g_bad_width
      $error("gk_qualifier: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             active;
   logic [CNT_W-1:0] run_cnt;
   logic [CNT_W:0]   run_next;
   logic             confirm;

   assign active   = enable && lvl_vld && (lvl == act_hi);
   assign run_next = {1'b0, run_cnt} + {{CNT_W{1'b0}}, 1'b1};
   assign confirm  = active && (run_next >= {1'b0, filt_len});

   // Consecutive-active counter, saturating, restarts on any inactive cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                run_cnt <= '0;
      else if (!active)          run_cnt <= '0;
      else if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
   end

   // Fault latch: a qualified fault wins over the clear strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       latched <= 1'b0;
      else if (confirm) latched <= 1'b1;
      else if (clr)     latched <= 1'b0;
   end

   assert_confirm_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
      confirm |=> latched);
   assert_no_rise_unqualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!latched && !confirm) |=> !latched);
   assert_hold_without_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (latched && !clr) |=> latched);
   assert_clear_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (latched && clr && !confirm) |=> !latched);
   assert_clear_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && confirm) |=> latched);
endmodule

// File: rtl/gk_gate_stage.sv
module gk_gate_stage #(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd,
   input  logic kill,
   input  logic act_hi,
   output logic pin
);
   import gk_pkg::*;

   logic on_state;

   if (OUT_REG) begin : g_registered
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) on_state <= 1'b0;
         else        on_state <= cmd & ~kill;
      end

      assert_kill_forces_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
         kill |=> (!$stable(act_hi) || pin == ~act_hi));
      assert_follow_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !kill |=> (!$stable(act_hi) || pin == ~($past(cmd) ^ act_hi)));
   end else begin : g_direct
      assign on_state = cmd & ~kill;
   end

   assign pin = to_pin(on_state, act_hi);
endmodule

// File: rtl/gate_kill_guard.sv
module gate_kill_guard #(
   parameter int N_INV       = 6,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_INV-1:0] inv_cmd,
   input  logic             pfc_cmd,
   input  logic             main_fault_pin,
   input  logic             pfc_fault_pin,
   input  logic             main_fault_hi,
   input  logic             pfc_fault_hi,
   input  logic             pfc_pin_is_gpio,
   input  logic [CNT_W-1:0] filt_len,
   input  logic             fault_clear,
   input  logic [N_INV-1:0] inv_act_hi,
   input  logic             pfc_act_hi,
   output logic [N_INV-1:0] inv_gate,
   output logic             pfc_gate
);
   if (N_INV < 1) begin : g_bad_ninv
      $error("gate_kill_guard: N_INV must be at least 1");
   end

   logic main_s, main_s_vld, pfc_s, pfc_s_vld;
   logic main_lat, pfc_lat, pfc_kill;

   gk_sync #(.STAGES(SYNC_STAGES)) u_sync_main (
      .clk(clk), .rst_n(rst_n), .d(main_fault_pin), .q(main_s), .q_vld(main_s_vld));
   gk_sync #(.STAGES(SYNC_STAGES)) u_sync_pfc (
      .clk(clk), .rst_n(rst_n), .d(pfc_fault_pin), .q(pfc_s), .q_vld(pfc_s_vld));

   gk_qualifier #(.CNT_W(CNT_W)) u_qual_main (
      .clk(clk), .rst_n(rst_n), .lvl_vld(main_s_vld), .lvl(main_s),
      .act_hi(main_fault_hi), .enable(1'b1), .filt_len(filt_len),
      .clr(fault_clear), .latched(main_lat));
   gk_qualifier #(.CNT_W(CNT_W)) u_qual_pfc (
      .clk(clk), .rst_n(rst_n), .lvl_vld(pfc_s_vld), .lvl(pfc_s),
      .act_hi(pfc_fault_hi), .enable(~pfc_pin_is_gpio), .filt_len(filt_len),
      .clr(fault_clear), .latched(pfc_lat));

   assign pfc_kill = pfc_pin_is_gpio ? main_lat : pfc_lat;

   for (genvar g = 0; g < N_INV; g++) begin : g_inv
      gk_gate_stage #(.OUT_REG(OUT_REG)) u_stage (
         .clk(clk), .rst_n(rst_n), .cmd(inv_cmd[g]), .kill(main_lat),
         .act_hi(inv_act_hi[g]), .pin(inv_gate[g]));
   end

   gk_gate_stage #(.OUT_REG(OUT_REG)) u_stage_pfc (
      .clk(clk), .rst_n(rst_n), .cmd(pfc_cmd), .kill(pfc_kill),
      .act_hi(pfc_act_hi), .pin(pfc_gate));

   if (OUT_REG) begin : g_top_chk
      assert_gpio_main_kills_pfc_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (pfc_pin_is_gpio && main_lat) |=> (!$stable(pfc_act_hi) || pfc_gate == ~pfc_act_hi));
      assert_pfc_fault_spares_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (pfc_lat && !main_lat) |=> (!$stable(inv_act_hi) || inv_gate == ~($past(inv_cmd) ^ inv_act_hi)));
   end
endmodule

// File: tb/test_gate_kill_guard.sv
module test_gate_kill_guard;
   localparam int N = 6;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] inv_cmd = '0;
   logic pfc_cmd = 1'b0;
   logic main_fault_pin = 1'b0, pfc_fault_pin = 1'b0;
   logic main_fault_hi = 1'b1, pfc_fault_hi = 1'b1, pfc_pin_is_gpio = 1'b0;
   logic [W-1:0] filt_len = 8'd4;
   logic fault_clear = 1'b0;
   logic [N-1:0] inv_act_hi = 6'b101010;
   logic pfc_act_hi = 1'b1;
   logic [N-1:0] inv_gate;
   logic pfc_gate;

   int checks = 0, failures = 0;
   string cur_req = "R10";

   always #5 clk = ~clk;

   gate_kill_guard i_gate_kill_guard (
      .clk(clk), .rst_n(rst_n), .inv_cmd(inv_cmd), .pfc_cmd(pfc_cmd),
      .main_fault_pin(main_fault_pin), .pfc_fault_pin(pfc_fault_pin),
      .main_fault_hi(main_fault_hi), .pfc_fault_hi(pfc_fault_hi),
      .pfc_pin_is_gpio(pfc_pin_is_gpio), .filt_len(filt_len),
      .fault_clear(fault_clear), .inv_act_hi(inv_act_hi), .pfc_act_hi(pfc_act_hi),
      .inv_gate(inv_gate), .pfc_gate(pfc_gate));

   // Behavioural reference: pin history, run lengths, latches, expected on-states.
   bit m_h1, m_h2, p_h1, p_h2, m_v1, m_v2, p_v1, p_v2;
   int run_m, run_p;
   bit lat_m, lat_p;
   bit [N-1:0] exp_inv_on;
   bit exp_pfc_on;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_h1 = 0; m_h2 = 0; p_h1 = 0; p_h2 = 0;
         m_v1 = 0; m_v2 = 0; p_v1 = 0; p_v2 = 0;
         run_m = 0; run_p = 0; lat_m = 0; lat_p = 0;
         exp_inv_on = '0; exp_pfc_on = 0;
      end else begin
         int need;
         bit am, ap, sm, sp, kp;
         need = (filt_len == 0) ? 1 : int'(filt_len);
         am = m_v2 && (m_h2 == main_fault_hi);
         ap = p_v2 && (p_h2 == pfc_fault_hi) && !pfc_pin_is_gpio;
         run_m = am ? run_m + 1 : 0;
         run_p = ap ? run_p + 1 : 0;
         sm = am && (run_m >= need);
         sp = ap && (run_p >= need);
         kp = pfc_pin_is_gpio ? lat_m : lat_p;
         exp_inv_on = lat_m ? '0 : inv_cmd;
         exp_pfc_on = kp ? 1'b0 : pfc_cmd;
         lat_m = sm || (lat_m && !fault_clear);
         lat_p = sp || (lat_p && !fault_clear);
         m_h2 = m_h1; m_v2 = m_v1; m_h1 = main_fault_pin; m_v1 = 1;
         p_h2 = p_h1; p_v2 = p_v1; p_h1 = pfc_fault_pin; p_v1 = 1;
      end
   end

   // Per-clock comparison against the model.
   always @(negedge clk) begin
      bit [N-1:0] e_inv;
      bit e_pfc;
      e_inv = ~(exp_inv_on ^ inv_act_hi);
      e_pfc = ~(exp_pfc_on ^ pfc_act_hi);
      checks++;
      if (inv_gate !== e_inv || pfc_gate !== e_pfc) begin
         failures++;
         $display("FAIL %s model: inv act=%b exp=%b pfc act=%b exp=%b",
                  cur_req, inv_gate, e_inv, pfc_gate, e_pfc);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [N-1:0] e_inv, input logic e_pfc);
      checks++;
      if (inv_gate !== e_inv || pfc_gate !== e_pfc) begin
         failures++;
         $display("FAIL %s: inv act=%b exp=%b pfc act=%b exp=%b",
                  req, inv_gate, e_inv, pfc_gate, e_pfc);
      end
   endtask

   task automatic do_clear();
      fault_clear = 1; cyc(1); fault_clear = 0; cyc(1);
   endtask

   initial begin
      #200000;
      failures++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R10: reset drives inactive levels (inverse of polarity).
      #3;
      chk("R10", 6'b010101, 1'b0);
      cyc(3);
      rst_n = 1; cyc(1);
      chk("R10", 6'b010101, 1'b0);

      // R11 / R8: pass-through under several polarities and commands.
      cur_req = "R11";
      inv_cmd = 6'b110011; pfc_cmd = 1; cyc(1);
      chk("R11", ~(6'b110011 ^ 6'b101010), 1'b1);
      cur_req = "R8";
      inv_act_hi = 6'b000000; pfc_act_hi = 0; cyc(2);
      chk("R8", ~6'b110011, 1'b0);
      inv_act_hi = 6'b111111; pfc_act_hi = 1;
      for (int k = 0; k < 8; k++) begin
         inv_cmd = 6'(k * 11); pfc_cmd = k[0]; cyc(1);
      end
      inv_cmd = 6'b111111; pfc_cmd = 1; cyc(2);

      // R4: a pulse one cycle short of filt_len (4) is rejected.
      cur_req = "R4";
      main_fault_pin = 1; cyc(3); main_fault_pin = 0; cyc(8);
      chk("R4", 6'b111111, 1'b1);
      // Exactly filt_len cycles is recognised; R1 PFC untouched.
      main_fault_pin = 1; cyc(4); main_fault_pin = 0; cyc(4);
      chk("R1", 6'b000000, 1'b1);
      // R6: latched after pin released.
      cur_req = "R6";
      cyc(10);
      chk("R6", 6'b000000, 1'b1);
      do_clear(); cyc(1);
      chk("R6", 6'b111111, 1'b1);

      // R7: clear during a held fault is ignored.
      cur_req = "R7";
      main_fault_pin = 1; cyc(10);
      do_clear();
      chk("R7", 6'b000000, 1'b1);
      main_fault_pin = 0; cyc(4);
      do_clear(); cyc(1);
      chk("R7", 6'b111111, 1'b1);

      // R3: active-low main fault pin.
      cur_req = "R3";
      main_fault_pin = 1; main_fault_hi = 0; cyc(6);
      chk("R3", 6'b111111, 1'b1);
      main_fault_pin = 0; cyc(8); main_fault_pin = 1; cyc(3);
      chk("R3", 6'b000000, 1'b1);
      do_clear(); cyc(1);
      main_fault_hi = 1; main_fault_pin = 0; cyc(4);
      chk("R3", 6'b111111, 1'b1);

      // R2: PFC fault shuts only the PFC gate (active-low PFC pin here too).
      cur_req = "R2";
      pfc_fault_pin = 1; pfc_fault_hi = 0; cyc(4);
      pfc_fault_pin = 0; cyc(8); pfc_fault_pin = 1; cyc(2);
      chk("R2", 6'b111111, 1'b0);
      do_clear(); cyc(1);
      chk("R2", 6'b111111, 1'b1);

      // R9: PFC pin in general-purpose mode; its level ignored, main kills PFC.
      cur_req = "R9";
      pfc_pin_is_gpio = 1; pfc_fault_pin = 0; cyc(12);
      chk("R9", 6'b111111, 1'b1);
      main_fault_pin = 1; cyc(8); main_fault_pin = 0; cyc(2);
      chk("R9", 6'b000000, 1'b0);
      do_clear(); cyc(1);
      chk("R9", 6'b111111, 1'b1);
      pfc_fault_pin = 1; pfc_pin_is_gpio = 0; cyc(4);

      // R5: latency with filt_len = 32.
      cur_req = "R5";
      filt_len = 8'd32; cyc(2);
      main_fault_pin = 1;
      cyc(32 + 2);
      chk("R5", 6'b111111, 1'b1);
      cyc(1);
      chk("R5", 6'b000000, 1'b1);
      main_fault_pin = 0; cyc(3); do_clear(); cyc(1);

      // R4: filt_len = 0 acts as 1; a single-cycle pulse is recognised.
      cur_req = "R4";
      filt_len = 8'd0; cyc(2);
      main_fault_pin = 1; cyc(1); main_fault_pin = 0; cyc(5);
      chk("R4", 6'b000000, 1'b1);
      do_clear(); cyc(2);
      chk("R4", 6'b111111, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule